// File: doc/BRIEF.md
# Amplifier Enable and Fault Sequencer

This block decides when the output bridge of a digital-input switching amplifier may switch. It watches three things: a shutdown request, activity on the incoming PDM bit clock, and a digital over-current flag from the current-sense circuit. It then drives a bridge enable, a high-impedance control for the bridge, and a 3-bit state code for observation. All timing is counted on a free-running reference clock. The PDM clock is asynchronous to it and only serves as an activity indicator.

After shutdown is released, the block waits in standby until the PDM clock toggles. It then holds the bridge quiet (driven, not switching) for a fixed warm-up period before enabling it. The bridge goes to high impedance at once on a shutdown request. It also goes to high impedance when the PDM clock has been silent for a programmable number of reference cycles. An over-current flag seen while the bridge is enabled starts a timed off period, after which the bridge is re-enabled. If the flag is still present, the off period repeats, so a persistent fault produces a hiccup pattern.

Top module: `amp_enable_seq`

## Requirements
- R1: During and right after reset the state code is 0 (off), `bridge_hiz` is 1 and `bridge_en` is 0.
- R2: While `shdn_req` is 1, `bridge_hiz` is 1 and `bridge_en` is 0 in the same cycle, with no clock edge needed. At the next reference edge the state becomes 0 (off), whatever the current state, fault or clock activity.
- R3: With `shdn_req` at 0, the off state moves to standby (code 1). Standby holds for as long as the PDM clock input does not toggle.
- R4: Once the PDM clock stops toggling, the block returns to standby (code 1) within `LOSS_CYC` to `LOSS_CYC`+5 reference cycles. This applies from warm-up, active and retry alike.
- R5: Leaving standby always passes through warm-up (code 2). Warm-up lasts exactly `WARM_CYC` reference cycles before the active state (code 3). Standby and off never go straight to active.
- R6: An over-current flag seen in the active state moves the block to retry (code 4). Retry lasts exactly `RETRY_CYC` cycles with the bridge in high impedance, then returns to active.
- R7: A flag held high produces one active cycle after each retry period, so the pattern repeats every `RETRY_CYC`+1 cycles.
- R8: The over-current flag is ignored during warm-up: the state stays 2 and warm-up completes to active.
- R9: State codes are 0 off, 1 standby, 2 warm-up, 3 active, 4 retry. `bridge_en` is 1 only in active. `bridge_hiz` is 1 in off, standby and retry, and 0 in warm-up and active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock for all timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_req | input | 1 | Shutdown request, active high |
| pdm_clk_in | input | 1 | PDM bit clock, asynchronous, used only for activity detection |
| oc_fault | input | 1 | Over-current flag from the current-sense circuit, active high |
| bridge_en | output | 1 | Bridge switching enable |
| bridge_hiz | output | 1 | Bridge high-impedance control |
| state_code | output | 3 | Current sequencer state |

## Verification
The sequencer is driven through a walk of input combinations: shutdown, clock present or absent, and fault pulses. Each combination is compared with the state code and with the enable and high-impedance pair it should produce. This separates the three bridge conditions: off/standby/retry, quiet warm-up, and switching. Warm-up and retry are timed cycle by cycle, which shows whether a timer is off by one. A held fault is used to confirm the single active cycle in each hiccup period, and a fault pulse during warm-up confirms that it is ignored. Stopping the clock from active and from retry measures the loss window. Asserting shutdown between clock edges confirms that the bridge goes to high impedance before any edge.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_WARM   = 3'd2,
    ST_RUN    = 3'd3,
    ST_HICCUP = 3'd4
  } amp_state_e;
endpackage

// File: rtl/pdm_activity_mon.sv
module pdm_activity_mon #(
  parameter int LOSS_CYC    = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pdm_in,
  output logic clk_alive
);
  localparam int CW = $clog2(LOSS_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYC);

  logic [SYNC_STAGES:0] sync_q;
  logic                 pdm_edge;
  logic [CW-1:0]        quiet_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], pdm_in};
  end

  // either polarity carries data, so both edges count as activity
  assign pdm_edge = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                quiet_cnt <= LIMIT;
    else if (pdm_edge)         quiet_cnt <= '0;
    else if (quiet_cnt != LIMIT) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign clk_alive = (quiet_cnt < LIMIT);
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 16
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (run && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/amp_seq_fsm.sv
module amp_seq_fsm
  import amp_seq_pkg::*;
#(
  parameter int WARM_CYC  = 81250,
  parameter int RETRY_CYC = 12500,
  parameter int W         = 17
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic         shdn_req,
  input  logic         clk_alive,
  input  logic         oc_fault,
  input  logic         tmr_done,
  output amp_state_e   state,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         tmr_run
);
  amp_state_e nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (shdn_req) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  nxt = ST_IDLE;
        ST_IDLE: if (clk_alive) begin
          nxt      = ST_WARM;
          tmr_load = 1'b1;
          tmr_val  = W'(WARM_CYC - 1);
        end
        ST_WARM: begin
          if (!clk_alive)    nxt = ST_IDLE;
          else if (tmr_done) nxt = ST_RUN;
        end
        ST_RUN: begin
          if (!clk_alive) nxt = ST_IDLE;
          else if (oc_fault) begin
            nxt      = ST_HICCUP;
            tmr_load = 1'b1;
            tmr_val  = W'(RETRY_CYC - 1);
          end
        end
        ST_HICCUP: begin
          if (!clk_alive)    nxt = ST_IDLE;
          else if (tmr_done) nxt = ST_RUN;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign tmr_run = (state == ST_WARM) || (state == ST_HICCUP);
endmodule

// File: rtl/amp_enable_seq.sv
module amp_enable_seq
  import amp_seq_pkg::*;
#(
  parameter int LOSS_CYC  = 125,
  parameter int WARM_CYC  = 81250,
  parameter int RETRY_CYC = 12500
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       shdn_req,
  input  logic       pdm_clk_in,
  input  logic       oc_fault,
  output logic       bridge_en,
  output logic       bridge_hiz,
  output logic [2:0] state_code
);
  localparam int TMR_MAX = (WARM_CYC > RETRY_CYC) ? WARM_CYC : RETRY_CYC;
  localparam int TW      = $clog2(TMR_MAX + 1);

  logic          clk_alive;
  logic          tmr_load, tmr_run, tmr_done;
  logic [TW-1:0] tmr_val;
  amp_state_e    state;

  pdm_activity_mon #(.LOSS_CYC(LOSS_CYC), .SYNC_STAGES(2)) u_mon (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .pdm_in   (pdm_clk_in),
    .clk_alive(clk_alive)
  );

  seq_timer #(.W(TW)) u_tmr (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .run     (tmr_run),
    .done    (tmr_done)
  );

  amp_seq_fsm #(.WARM_CYC(WARM_CYC), .RETRY_CYC(RETRY_CYC), .W(TW)) u_fsm (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .shdn_req (shdn_req),
    .clk_alive(clk_alive),
    .oc_fault (oc_fault),
    .tmr_done (tmr_done),
    .state    (state),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tmr_run  (tmr_run)
  );

  // shutdown acts on the bridge without waiting for a reference edge
  assign bridge_en  = (state == ST_RUN) && !shdn_req;
  assign bridge_hiz = shdn_req || !((state == ST_RUN) || (state == ST_WARM));
  assign state_code = state;
endmodule

// File: rtl/amp_seq_chk.sv
module amp_seq_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       shdn_req,
  input logic       oc_fault,
  input logic       clk_alive,
  input logic       bridge_en,
  input logic       bridge_hiz,
  input logic [2:0] state_code
);
  a_r2_shdn_to_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
    shdn_req |=> (state_code == 3'd0));

  a_r9_en_not_hiz: assert property (@(posedge ref_clk) disable iff (!rst_n)
    bridge_en |-> !bridge_hiz);

  a_r9_code_legal: assert property (@(posedge ref_clk) disable iff (!rst_n)
    state_code <= 3'd4);

  a_r5_idle_no_run: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state_code == 3'd1) |=> (state_code != 3'd3));

  a_r5_run_entry: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state_code == 3'd3 && $past(state_code) != 3'd3) |->
      ($past(state_code) == 3'd2 || $past(state_code) == 3'd4));

  a_r6_fault_leaves_run: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state_code == 3'd3 && oc_fault && !shdn_req) |=>
      (state_code == 3'd4 || state_code == 3'd1));

  a_r4_loss_to_idle: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!clk_alive && !shdn_req && state_code >= 3'd2) |=> (state_code == 3'd1));
endmodule

bind amp_enable_seq amp_seq_chk u_chk (
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .shdn_req  (shdn_req),
  .oc_fault  (oc_fault),
  .clk_alive (clk_alive),
  .bridge_en (bridge_en),
  .bridge_hiz(bridge_hiz),
  .state_code(state_code)
);

// File: tb/tb_amp_enable_seq.sv
`timescale 1ns/1ps
module tb_amp_enable_seq;
  localparam int L = 16;
  localparam int S = 40;
  localparam int R = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn = 1'b1;
  logic pdm = 1'b0;
  logic pdm_run = 1'b0;
  logic fault = 1'b0;
  logic en, hiz;
  logic [2:0] code;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  amp_enable_seq #(.LOSS_CYC(L), .WARM_CYC(S), .RETRY_CYC(R)) dut (
    .ref_clk(clk), .rst_n(rst_n), .shdn_req(shdn), .pdm_clk_in(pdm),
    .oc_fault(fault), .bridge_en(en), .bridge_hiz(hiz), .state_code(code)
  );

  always @(negedge clk) if (pdm_run) pdm = ~pdm;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=%0d cycles expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_en(input int s); return s == 3; endfunction
  function automatic bit exp_hiz(input int s); return !(s == 2 || s == 3); endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_code(input int s, input int lim);
    for (int i = 0; i < lim; i++) begin
      if (code == 3'(s)) return;
      @(negedge clk);
    end
  endtask

  // {shdn, clock running, fault, wait cycles[7:0], expected state[2:0]}
  localparam logic [13:0] VEC [0:8] = '{
    {1'b1, 1'b0, 1'b0, 8'd5,  3'd0},
    {1'b0, 1'b0, 1'b0, 8'd5,  3'd1},
    {1'b0, 1'b1, 1'b0, 8'd10, 3'd2},
    {1'b0, 1'b1, 1'b0, 8'd50, 3'd3},
    {1'b0, 1'b1, 1'b1, 8'd4,  3'd4},
    {1'b0, 1'b1, 1'b0, 8'd30, 3'd3},
    {1'b0, 1'b0, 1'b0, 8'd30, 3'd1},
    {1'b0, 1'b1, 1'b0, 8'd10, 3'd2},
    {1'b1, 1'b1, 1'b0, 8'd3,  3'd0}
  };

  initial begin
    int n;
    int ens;
    int hb;
    // R1: reset state
    cycles(3);
    chk(code == 3'd0, "R1 code in reset", code, 0);
    chk(hiz && !en, "R1 hiz/en in reset", {hiz, en}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code == 3'd0 && hiz && !en, "R1 after reset", code, 0);

    // R9 table walk
    for (int v = 0; v < 9; v++) begin
      shdn = VEC[v][13]; pdm_run = VEC[v][12]; fault = VEC[v][11];
      cycles(int'(VEC[v][10:3]));
      chk(code == VEC[v][2:0], $sformatf("R9 vec%0d code", v), code, VEC[v][2:0]);
      chk(en == exp_en(VEC[v][2:0]) && hiz == exp_hiz(VEC[v][2:0]),
          $sformatf("R9 vec%0d en/hiz", v), {en, hiz},
          {exp_en(VEC[v][2:0]), exp_hiz(VEC[v][2:0])});
    end

    // R3: standby holds without clock
    pdm_run = 1'b0; shdn = 1'b0;
    cycles(40);
    chk(code == 3'd1, "R3 standby holds", code, 1);

    // R5: warm-up length exactly S
    pdm_run = 1'b1;
    n = 0;
    for (int i = 0; i < 200 && code != 3'd3; i++) begin
      if (code == 3'd2) n++;
      @(negedge clk);
    end
    chk(n == S, "R5 warm-up cycles", n, S);
    chk(code == 3'd3, "R5 reaches active", code, 3);

    // R6: retry length exactly R with hiz high
    fault = 1'b1; @(negedge clk); fault = 1'b0;
    n = 0; hb = 0;
    for (int i = 0; i < 200 && code != 3'd3; i++) begin
      if (code == 3'd4) begin n++; if (!hiz || en) hb++; end
      @(negedge clk);
    end
    chk(n == R, "R6 retry cycles", n, R);
    chk(hb == 0, "R6 hiz during retry", hb, 0);

    // R7: persistent fault hiccup
    fault = 1'b1;
    wait_code(4, 50);
    ens = 0; n = 0;
    for (int i = 0; i < 3 * (R + 1); i++) begin
      if (en) ens++;
      if (code == 3'd4) n++;
      @(negedge clk);
    end
    chk(ens == 3, "R7 active cycles per window", ens, 3);
    chk(n == 3 * R, "R7 retry cycles per window", n, 3 * R);

    // R4: loss while in retry, fault still held
    pdm_run = 1'b0;
    cycles(L + 8);
    chk(code == 3'd1, "R4 loss from retry", code, 1);
    fault = 1'b0;

    // R8: fault ignored during warm-up
    pdm_run = 1'b1;
    wait_code(2, 50);
    fault = 1'b1; cycles(5);
    chk(code == 3'd2, "R8 warm-up holds under fault", code, 2);
    fault = 1'b0;
    wait_code(3, 100);
    chk(code == 3'd3, "R8 warm-up completes", code, 3);

    // R4: loss timing from active
    pdm_run = 1'b0;
    n = 0;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (code == 3'd1) begin n = i; break; end
    end
    chk(n >= L && n <= L + 5, "R4 loss window", n, L + 4);

    // R2: immediate shutdown from active
    pdm_run = 1'b1;
    wait_code(3, 100);
    shdn = 1'b1; #1;
    chk(hiz && !en, "R2 immediate hiz", {hiz, en}, 2);
    @(negedge clk);
    chk(code == 3'd0, "R2 off next edge", code, 0);

    // R2: shutdown beats retry
    shdn = 1'b0;
    wait_code(3, 100);
    fault = 1'b1; @(negedge clk); fault = 1'b0;
    chk(code == 3'd4, "R2 in retry before shutdown", code, 4);
    shdn = 1'b1; @(negedge clk);
    chk(code == 3'd0, "R2 off from retry", code, 0);
    shdn = 1'b0; cycles(2);
    chk(code != 3'd3, "R5 no direct active after off", code, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule